// File: doc/BRIEF.md
# Interleaved Circulating Display Memory

This block holds the raster image of one display path as a serial store that loops on itself. The store is split into two banks of equal size. One bank holds the first, third, fifth... bit of the image and the other holds the second, fourth, sixth... bit. Each bank advances once per memory period. A memory period is two cycles of the block clock. In the first cycle the block presents the bit from the first bank, and in the second cycle it presents the bit from the second bank. The result is a video stream of one bit per clock, which is twice the rate of either bank.

While no load is running, nothing is written and the image loops unchanged, so it is always ready for display. To replace the image, a caller raises `load_en` in the cycle where `frame_start` is high. The block then takes `din` one bit per clock for exactly one full loop. During that loop the new bits take the place of the looping data, and `video_out` still shows the previous image. The first bank's bit is held for one cycle, so both banks are written together at the end of each memory period.

Top module: `circ_display_mem`

## Requirements
- R1: `frame_start` is high for the one cycle that presents image bit 0, and it recurs every 2·WORD_W·DEPTH cycles.
- R2: `video_out` presents one image bit per clock, in image order, with bit n of the loop presenting stored image bit n (n counted from 0). The phase alternates every clock: even n comes from the first bank and odd n from the second bank.
- R3: When `load_en` is high in a `frame_start` cycle, the `din` value in cycle k of that loop (k = 0 being the `frame_start` cycle) becomes image bit k.
- R4: The bits with even n of a loaded stream go to the first bank and the bits with odd n go to the second bank. Each first-bank bit is held one cycle, and then both banks are written in the same cycle (the second cycle of the memory period).
- R5: A load lasts exactly one loop of 2·WORD_W·DEPTH cycles. `load_en` has no effect outside a `frame_start` cycle, and it cannot stretch a load once the load has begun.
- R6: Without a load, the stored image loops unchanged for any number of loops.
- R7: During a load, `video_out` shows the previous image, and the new image appears from the next `frame_start`.
- R8: Reset, which is asynchronous and active low and released two clocks after `rst_n` rises, puts the position at image bit 0 in the first phase, so `frame_start` reads high. Reset does not change the stored image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two cycles per memory period |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load request, sampled only while frame_start is high |
| din | input | 1 | Serial image data, one bit per clock during a load |
| video_out | output | 1 | Serial video, one image bit per clock |
| frame_start | output | 1 | High in the cycle that presents image bit 0 |

## Verification
`video_out` and `frame_start` are decoded from the position registers, so each is valid in the same cycle as the position it describes. The bench samples both on the falling edge and compares bit n of a loop against image bit n. A load that starts in a `frame_start` cycle changes nothing visible for 2·WORD_W·DEPTH cycles; the new image is checked from the next `frame_start`, and the old image is checked during the load itself. After `rst_n` rises, the bench expects `frame_start` on two falling edges, and the loop count starts at the second of them.

// File: rtl/cdm_pkg.sv
`timescale 1ns/1ps
package cdm_pkg;
  // half of a memory period: which bank drives the video output
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/cdm_seq.sv
`timescale 1ns/1ps
// Position sequencer: half-period phase, bit within word, word address.
module cdm_seq
  import cdm_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  output half_e         phase,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] bit_idx,
  output logic          frame_start,
  output logic          frame_last
);
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(WORD_W - 1);

  half_e         phase_q, phase_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          word_end;

  always_comb begin
    phase_d  = (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    bit_d    = bit_q;
    addr_d   = addr_q;
    word_end = (bit_q == BIT_LAST);
    if (phase_q == PH_SECOND) begin
      if (word_end) begin
        bit_d  = '0;
        addr_d = (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      bit_q   <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      addr_q  <= addr_d;
    end
  end

  assign phase       = phase_q;
  assign addr        = addr_q;
  assign bit_idx     = bit_q;
  assign frame_start = (phase_q == PH_FIRST) && (addr_q == '0) && (bit_q == '0);
  assign frame_last  = (phase_q == PH_SECOND) && (addr_q == ADDR_LAST) && word_end;
endmodule

// File: rtl/cdm_load.sv
`timescale 1ns/1ps
// Load control: one-loop load window, first-bank hold, paired write strobe.
module cdm_load
  import cdm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  half_e phase,
  input  logic  frame_start,
  input  logic  frame_last,
  input  logic  load_en,
  input  logic  din,
  output logic  load_busy,
  output logic  bank_we,
  output logic  first_wdata
);
  logic busy_q, busy_d;
  logic hold_q, hold_d;
  logic hold_en;
  logic load_active;

  always_comb begin
    load_active = frame_start ? load_en : busy_q;
    busy_d      = load_active && !frame_last;
    hold_en     = load_active && (phase == PH_FIRST);
    hold_d      = hold_en ? din : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      hold_q <= hold_d;
    end
  end

  assign load_busy   = busy_q;
  assign bank_we     = load_active && (phase == PH_SECOND);
  assign first_wdata = hold_q;
endmodule

// File: rtl/cdm_bank.sv
`timescale 1ns/1ps
// One bank: DEPTH words of WORD_W bits, bit-addressed write, direct read.
module cdm_bank #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bit_idx,
  input  logic          wdata,
  output logic          rdata
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[addr][bit_idx] <= wdata;
    end
  end

  assign rdata = store[addr][bit_idx];
endmodule

// File: rtl/circ_display_mem.sv
`timescale 1ns/1ps
module circ_display_mem
  import cdm_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic din,
  output logic video_out,
  output logic frame_start
);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(WORD_W);
  localparam int NBANK = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  half_e            phase;
  logic [AW-1:0]    addr;
  logic [BW-1:0]    bit_idx;
  logic             frame_last;
  logic             load_busy;
  logic             bank_we;
  logic             first_wdata;
  logic [NBANK-1:0] bank_wdata;
  logic [NBANK-1:0] bank_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cdm_seq #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phase      (phase),
    .addr       (addr),
    .bit_idx    (bit_idx),
    .frame_start(frame_start),
    .frame_last (frame_last)
  );

  cdm_load u_load (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phase      (phase),
    .frame_start(frame_start),
    .frame_last (frame_last),
    .load_en    (load_en),
    .din        (din),
    .load_busy  (load_busy),
    .bank_we    (bank_we),
    .first_wdata(first_wdata)
  );

  assign bank_wdata = {din, first_wdata};

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    cdm_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_bank (
      .clk    (clk),
      .we     (bank_we),
      .addr   (addr),
      .bit_idx(bit_idx),
      .wdata  (bank_wdata[g]),
      .rdata  (bank_rdata[g])
    );
  end

  assign video_out = (phase == PH_FIRST) ? bank_rdata[0] : bank_rdata[1];
endmodule

// File: rtl/cdm_checker.sv
`timescale 1ns/1ps
module cdm_checker #(
  parameter int FRAME_BITS = 36864
) (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic load_en,
  input logic din,
  input logic phase,
  input logic load_busy,
  input logic bank_we,
  input logic first_wdata
);
  localparam int CW = $clog2(FRAME_BITS) + 1;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= (cyc_q == CW'(FRAME_BITS - 1)) ? '0 : cyc_q + 1'b1;
  end

  assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start == (cyc_q == '0));

  assert_phase_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> !phase);

  assert_phase_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> phase);

  assert_load_begins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && load_en) |=> load_busy);

  assert_first_bank_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (first_wdata == $past(din)));

  assert_load_ends_at_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !load_busy);

  assert_no_midloop_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !load_busy) |=> !load_busy);

  assert_no_idle_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> load_busy);
endmodule

bind circ_display_mem cdm_checker #(.FRAME_BITS(2 * WORD_W * DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .frame_start(frame_start),
  .load_en    (load_en),
  .din        (din),
  .phase      (phase),
  .load_busy  (load_busy),
  .bank_we    (bank_we),
  .first_wdata(first_wdata)
);

// File: tb/sim_circ_display_mem.sv
`timescale 1ns/1ps
module sim_circ_display_mem;
  localparam int WW = 3;
  localparam int DP = 4;
  localparam int N  = 2 * WW * DP;

  logic clk = 1'b0;
  logic rst_n, load_en, din;
  logic video_out, frame_start;
  int   checks = 0;
  int   fails  = 0;
  bit   img [N];
  bit   known = 0;

  always #2.5 clk = ~clk;

  circ_display_mem #(.WORD_W(WW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .din(din),
    .video_out(video_out), .frame_start(frame_start)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pat_bit(input int kind, input int i);
    case (kind)
      0:       return (i % 3) == 0;
      1:       return i[0];
      2:       return ((i * 7 + 3) % 5) < 2;
      3:       return 1'b1;
      default: return (((i * 13) ^ (i >> 1)) & 1) == 1;
    endcase
  endfunction

  // precondition: at the falling edge of a frame_start cycle
  task automatic load_frame(input int kind, input bit hold, input string req);
    int bad = 0;
    int first_bad = -1;
    chk(frame_start === 1'b1, "R3", "frame_start at load begin", frame_start, 1);
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      if (known && video_out !== img[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      load_en = (i == 0) || hold;
      din     = pat_bit(kind, i);
    end
    @(negedge clk);
    load_en = 1'b0;
    din     = 1'b0;
    if (known)
      chk(bad == 0, "R7", "old image shown during load, mismatches", bad, 0);
    chk(frame_start === 1'b1, "R5", "load spans one loop", frame_start, 1);
    for (int i = 0; i < N; i++) img[i] = pat_bit(kind, i);
    known = 1;
    $display("loaded pattern %0d (%s)", kind, req);
  endtask

  // precondition: at the falling edge of a frame_start cycle
  task automatic read_frame(input string req);
    int bad = 0;
    int first_bad = -1;
    int fs_cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      if (video_out !== img[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      if (i > 0 && frame_start) fs_cnt++;
    end
    @(negedge clk);
    chk(bad == 0, req, "image readback mismatches", bad, 0);
    if (bad != 0) $display("  first mismatch at bit %0d", first_bad);
    chk(fs_cnt == 0 && frame_start === 1'b1, "R1", "frame_start only at loop start",
        fs_cnt, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_en = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_start === 1'b1, "R8", "frame_start during reset release", frame_start, 1);
    @(negedge clk);
    chk(frame_start === 1'b1, "R8", "first loop slot after release", frame_start, 1);
  endtask

  task automatic t_period();
    int fs_cnt = 0;
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      if (frame_start) fs_cnt++;
    end
    chk(fs_cnt == 0, "R1", "no frame_start inside loop", fs_cnt, 0);
    @(negedge clk);
    chk(frame_start === 1'b1, "R1", "frame_start after N cycles", frame_start, 1);
  endtask

  task automatic t_stray_load();
    for (int i = 0; i < N; i++) begin
      if (i > 0) @(negedge clk);
      load_en = (i != 0);
      din     = ~img[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    din     = 1'b0;
    read_frame("R5");
  endtask

  task automatic t_midrun_reset();
    repeat (N / 2 + 1) @(negedge clk);
    t_reset();
    read_frame("R8");
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    load_frame(0, 1'b0, "R3");
    read_frame("R2");
    read_frame("R6");
    load_frame(1, 1'b0, "R4");
    read_frame("R4");
    load_frame(2, 1'b1, "R5");
    read_frame("R5");
    load_frame(3, 1'b0, "R7");
    load_frame(4, 1'b0, "R7");
    read_frame("R7");
    t_stray_load();
    read_frame("R6");
    t_midrun_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule